// File: doc/BRIEF.md
# Banked Dual-Port Transparent Register File

This block stores a few short words in a set of identical banks. Each bank holds four words of four bits. Each bank has its own active-low write enable and its own active-low read enable. The write address, write data and read address are shared by all banks, as if the banks were wired side by side on a board. A write and a read run at the same time and are independent. One word can be loaded while another word, in the same bank or in a different one, is being read.

Writes are taken at the rising clock edge for every cycle in which a bank's write enable is low. Reads are combinational. A word that is being written is transparent. If the read address matches the write address of the bank being read, the output shows the incoming data in the same cycle and does not wait for the stored copy. The banks do not drive a shared tri-state bus. Each bank reports its word together with an output-enable flag. The top merges these flags into one output word, a drive flag and a clash flag. The clash flag is raised when more than one bank is enabled at once. A synchronous clear zeroes every word, because the contents are undefined after power-up.

Top module: `xrf_bank_array`

## Requirements
- R1: When bank b has `wr_en_n[b]` low at a rising edge and `clr` is low, word `wr_addr` of bank b holds `wr_data` after that edge. Other words and other banks are unchanged.
- R2: A bank whose `wr_en_n` bit is high at an edge keeps every word unchanged, whatever `wr_addr` and `wr_data` carry.
- R3: With exactly one bit of `rd_en_n` low, `rd_drive` is 1 and `rd_data` equals the stored word at `rd_addr` of that bank, in the same cycle. The read address is decoded whatever the write enables are.
- R4: With every bit of `rd_en_n` high, `rd_drive` is 0 and `rd_data` is all zeros. This stands for the high-impedance state.
- R5: When the bank being read has its write enable low and `wr_addr` equals `rd_addr`, `rd_data` equals `wr_data` in that same cycle. It keeps following `wr_data` for as long as the enable stays low.
- R6: A write to one word while another word of the same bank is read returns the old stored value of the word being read.
- R7: A bank that is written repeatedly over consecutive cycles ends up holding the data of its last write cycle.
- R8: `clr` high at an edge sets every word of every bank to zero, and takes priority over a write in that cycle.
- R9: `rd_clash` is 1 exactly when two or more bits of `rd_en_n` are low. In that case `rd_data` is the bitwise OR of the words the enabled banks present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Synchronous clear of all words, active high |
| wr_en_n | input | BANKS | Per-bank write enable, active low |
| wr_addr | input | ADDR_W | Word select for writes, shared by all banks |
| wr_data | input | DATA_W | Write data, shared by all banks |
| rd_en_n | input | BANKS | Per-bank read enable, active low |
| rd_addr | input | ADDR_W | Word select for reads, shared by all banks |
| rd_data | output | DATA_W | Merged read word, zero when no bank drives |
| rd_drive | output | 1 | At least one bank is driving the output |
| rd_clash | output | 1 | More than one bank is driving the output |

## Verification
The bench targets the write-through path. It holds a write enable low across several cycles while the data changes and the read address matches the write address. A design that reads only the stored copy would lag one cycle behind. The bench also reads a neighbouring word while another word is written, which catches a bypass that ignores the address compare. It drives garbage on the address and data with the write enable high, which exposes a store that does not gate on the enable. It asserts clear and write in the same cycle, to expose the wrong priority. It enables two banks at once, which catches a clash detector that counts wrongly or is missing.

// File: rtl/xrf_pkg.sv
package xrf_pkg;
    localparam int unsigned XRF_DATA_W = 4;
    localparam int unsigned XRF_WORDS  = 4;
    localparam int unsigned XRF_BANKS  = 2;
endpackage

// File: rtl/xrf_word_store.sv
module xrf_word_store #(
    parameter int unsigned DATA_W = xrf_pkg::XRF_DATA_W,
    parameter int unsigned WORDS  = xrf_pkg::XRF_WORDS,
    localparam int unsigned ADDR_W = $clog2(WORDS)
) (
    input  logic                          clk,
    input  logic                          clr,
    input  logic                          wr_en_n,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [WORDS-1:0][DATA_W-1:0]  words
);
    typedef struct packed {
        logic [WORDS-1:0][DATA_W-1:0] mem;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.mem = '0;
        end else if (!wr_en_n) begin
            st_d.mem[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign words = st_q.mem;
endmodule

// File: rtl/xrf_read_port.sv
module xrf_read_port #(
    parameter int unsigned DATA_W = xrf_pkg::XRF_DATA_W,
    parameter int unsigned WORDS  = xrf_pkg::XRF_WORDS,
    localparam int unsigned ADDR_W = $clog2(WORDS)
) (
    input  logic [WORDS-1:0][DATA_W-1:0]  words,
    input  logic                          wr_en_n,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          rd_en_n,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             port_data,
    output logic                          port_oe
);
    logic              pass_through;
    logic [DATA_W-1:0] picked;

    always_comb begin
        pass_through = !wr_en_n && (wr_addr == rd_addr);
        picked       = pass_through ? wr_data : words[rd_addr];
        port_oe      = !rd_en_n;
        port_data    = port_oe ? picked : '0;
    end
endmodule

// File: rtl/xrf_bus_merge.sv
module xrf_bus_merge #(
    parameter int unsigned DATA_W = xrf_pkg::XRF_DATA_W,
    parameter int unsigned BANKS  = xrf_pkg::XRF_BANKS
) (
    input  logic [BANKS-1:0][DATA_W-1:0]  bank_data,
    input  logic [BANKS-1:0]              bank_oe,
    output logic [DATA_W-1:0]             bus_data,
    output logic                          bus_any,
    output logic                          bus_clash
);
    always_comb begin
        bus_data  = '0;
        bus_any   = 1'b0;
        bus_clash = 1'b0;
        for (int b = 0; b < BANKS; b++) begin
            if (bank_oe[b]) begin
                if (bus_any) bus_clash = 1'b1;
                bus_any  = 1'b1;
                bus_data = bus_data | bank_data[b];
            end
        end
    end
endmodule

// File: rtl/xrf_bank_array.sv
module xrf_bank_array #(
    parameter int unsigned DATA_W = xrf_pkg::XRF_DATA_W,
    parameter int unsigned WORDS  = xrf_pkg::XRF_WORDS,
    parameter int unsigned BANKS  = xrf_pkg::XRF_BANKS,
    localparam int unsigned ADDR_W = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               clr,
    input  logic [BANKS-1:0]   wr_en_n,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [BANKS-1:0]   rd_en_n,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_drive,
    output logic               rd_clash
);
    logic [BANKS-1:0][DATA_W-1:0] bank_data;
    logic [BANKS-1:0]             bank_oe;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [WORDS-1:0][DATA_W-1:0] words;

        xrf_word_store #(.DATA_W(DATA_W), .WORDS(WORDS)) u_store (
            .clk     (clk),
            .clr     (clr),
            .wr_en_n (wr_en_n[b]),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .words   (words)
        );

        xrf_read_port #(.DATA_W(DATA_W), .WORDS(WORDS)) u_rd (
            .words     (words),
            .wr_en_n   (wr_en_n[b]),
            .wr_addr   (wr_addr),
            .wr_data   (wr_data),
            .rd_en_n   (rd_en_n[b]),
            .rd_addr   (rd_addr),
            .port_data (bank_data[b]),
            .port_oe   (bank_oe[b])
        );
    end

    xrf_bus_merge #(.DATA_W(DATA_W), .BANKS(BANKS)) u_merge (
        .bank_data (bank_data),
        .bank_oe   (bank_oe),
        .bus_data  (rd_data),
        .bus_any   (rd_drive),
        .bus_clash (rd_clash)
    );
endmodule

// File: rtl/xrf_bank_array_chk.sv
module xrf_bank_array_chk #(
    parameter int unsigned DATA_W = 4,
    parameter int unsigned WORDS  = 4,
    parameter int unsigned BANKS  = 2,
    localparam int unsigned ADDR_W = $clog2(WORDS)
) (
    input logic               clk,
    input logic               clr,
    input logic [BANKS-1:0]   wr_en_n,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [DATA_W-1:0]  wr_data,
    input logic [BANKS-1:0]   rd_en_n,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic [DATA_W-1:0]  rd_data,
    input logic               rd_drive,
    input logic               rd_clash
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (clr)
        (&rd_en_n) |-> (!rd_drive && rd_data == '0)); // R4

    AST_ONE_DRIVES: assert property (@(posedge clk) disable iff (clr)
        ($countones(~rd_en_n) == 1) |-> (rd_drive && !rd_clash)); // R3

    AST_CLASH_SEEN: assert property (@(posedge clk) disable iff (clr)
        ($countones(~rd_en_n) > 1) |-> rd_clash); // R9

    AST_BYPASS_LIVE: assert property (@(posedge clk) disable iff (clr)
        ($countones(~rd_en_n) == 1 && ((~wr_en_n & ~rd_en_n) != '0)
         && wr_addr == rd_addr) |-> (rd_data == wr_data)); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (clr)
        ((&wr_en_n) && $countones(~rd_en_n) == 1) |=>
        (!($stable(rd_addr) && $stable(rd_en_n) && (&wr_en_n)) || $stable(rd_data))); // R2
endmodule

bind xrf_bank_array xrf_bank_array_chk #(
    .DATA_W(DATA_W), .WORDS(WORDS), .BANKS(BANKS)
) u_chk (
    .clk(clk), .clr(clr), .wr_en_n(wr_en_n), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en_n(rd_en_n), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_drive(rd_drive), .rd_clash(rd_clash)
);

// File: tb/xrf_bank_array_bench.sv
`timescale 1ns/1ps
module xrf_bank_array_bench;
    localparam int DW = 4;
    localparam int NW = 4;
    localparam int NB = 2;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          clr = 1'b1;
    logic [NB-1:0] wr_en_n = '1;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NB-1:0] rd_en_n = '1;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          rd_drive;
    logic          rd_clash;

    int ref_mem [NB][NW];
    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    xrf_bank_array u_xrf_bank_array (
        .clk(clk), .clr(clr), .wr_en_n(wr_en_n), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en_n(rd_en_n), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_drive(rd_drive), .rd_clash(rd_clash)
    );

    task automatic step(input logic [NB-1:0] wen, input int wa, input int wd,
                        input logic [NB-1:0] ren, input int ra, input logic c,
                        input string tag);
        int exp_d;
        int n_on;
        @(negedge clk);
        wr_en_n = wen; wr_addr = AW'(wa); wr_data = DW'(wd);
        rd_en_n = ren; rd_addr = AW'(ra); clr = c;
        #1;
        exp_d = 0;
        n_on  = 0;
        for (int b = 0; b < NB; b++) begin
            if (!ren[b]) begin
                n_on++;
                if (!wen[b] && wa == ra) exp_d = exp_d | (wd & 15);
                else                     exp_d = exp_d | ref_mem[b][ra];
            end
        end
        n_checks++;
        if (int'(rd_data) != exp_d || rd_drive != (n_on > 0) || rd_clash != (n_on > 1)) begin
            n_fails++;
            $display("FAIL %s: data=%0h drive=%0b clash=%0b expected data=%0h drive=%0b clash=%0b",
                     tag, rd_data, rd_drive, rd_clash, exp_d, n_on > 0, n_on > 1);
        end
        for (int b = 0; b < NB; b++) begin
            for (int w = 0; w < NW; w++) begin
                if (c) ref_mem[b][w] = 0;
                else if (!wen[b] && w == wa) ref_mem[b][w] = wd & 15;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NB; b++)
            for (int w = 0; w < NW; w++) ref_mem[b][w] = 0;
        // R8: clear, idle output during clear (R4)
        step(2'b11, 0, 0, 2'b11, 0, 1'b1, "R4 idle in clear");
        step(2'b00, 1, 9, 2'b11, 0, 1'b1, "R8 clear beats write");
        for (int w = 0; w < NW; w++) begin
            step(2'b11, 0, 0, 2'b10, w, 1'b0, "R8 bank0 cleared");
            step(2'b11, 0, 0, 2'b01, w, 1'b0, "R8 bank1 cleared");
        end
        // R1: fill both banks with distinct values
        for (int w = 0; w < NW; w++) begin
            step(2'b10, w, 3 + w, 2'b11, 0, 1'b0, "R1 write bank0");
            step(2'b01, w, 12 - w, 2'b11, 0, 1'b0, "R1 write bank1");
        end
        for (int w = 0; w < NW; w++) begin
            step(2'b11, 0, 0, 2'b10, w, 1'b0, "R3 read bank0");
            step(2'b11, 0, 0, 2'b01, w, 1'b0, "R3 read bank1");
        end
        // R2: garbage on write bus with enables high
        for (int w = 0; w < NW; w++)
            step(2'b11, w, 15 - w, 2'b10, w, 1'b0, "R2 no write when disabled");
        for (int w = 0; w < NW; w++)
            step(2'b11, 3 - w, 6, 2'b01, w, 1'b0, "R2 bank1 unchanged");
        // R6: write one word, read another in same bank
        step(2'b10, 1, 14, 2'b10, 2, 1'b0, "R6 read other word during write");
        step(2'b11, 0, 0, 2'b10, 1, 1'b0, "R1 readback written word");
        // R3: read decode while the other bank writes
        step(2'b01, 2, 5, 2'b10, 2, 1'b0, "R3 read bank0 while bank1 writes");
        // R5 and R7: held write enable, live data follows
        step(2'b01, 3, 1, 2'b01, 3, 1'b0, "R5 write-through first");
        step(2'b01, 3, 8, 2'b01, 3, 1'b0, "R5 write-through follows");
        step(2'b01, 3, 10, 2'b01, 3, 1'b0, "R5 write-through follows again");
        step(2'b11, 0, 0, 2'b01, 3, 1'b0, "R7 last write kept");
        // R9: two banks enabled
        step(2'b11, 0, 0, 2'b00, 0, 1'b0, "R9 clash");
        step(2'b11, 0, 0, 2'b00, 3, 1'b0, "R9 clash other word");
        step(2'b11, 0, 0, 2'b11, 3, 1'b0, "R4 idle after clash");
        // mixed traffic against the model
        for (int i = 0; i < 300; i++)
            step(NB'($urandom_range(0, 3)), $urandom_range(0, 3), $urandom_range(0, 15),
                 NB'($urandom_range(0, 3)), $urandom_range(0, 3), 1'b0, "R3 mixed traffic");
        // R8 again mid-run
        step(2'b11, 0, 0, 2'b11, 0, 1'b1, "R8 clear mid-run");
        for (int w = 0; w < NW; w++)
            step(2'b11, 0, 0, 2'b01, w, 1'b0, "R8 zero after clear");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule